// File: doc/BRIEF.md
# Speculative load conflict table

This block keeps track of loads that a scheduler has moved above older stores. When such a load issues, its destination tag and address go into a small fully associative table. Every later store compares its address against all live entries. A store that writes the same word as a recorded load removes that entry, which marks the entry as violated.

At the load's original place in program order, a check names the tag. One cycle later the block answers whether the load must run again. A check that finds no live entry with that tag asks for a replay. This covers three cases: a conflicting store, a load that was never recorded, and an entry pushed out by a newer insert. The check also retires the entry it tests.

When the same cycle carries more than one operation, they take effect in a fixed order: the store first, then the check, then the insert.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table holds no entries, `resp_valid` is 0, and a check of any tag answers replay.
- R2: `resp_valid` is 1 in exactly the cycle after a cycle with `chk_valid` high. `resp_replay` is 0 whenever `resp_valid` is 0.
- R3: An entry is violated by a store whose address equals the entry's address in bits [ADDR_W-1:2], whatever bits [1:0] hold. A later check of that tag answers replay.
- R4: A store to a different word leaves the entry alone. A check of that tag answers no replay, and other tags are never affected.
- R5: A check retires the entry it tests, so a second check of the same tag answers replay.
- R6: Inserting a tag that is already live overwrites that entry's address. Stores to the old word no longer conflict, while stores to the new word do.
- R7: The table holds ENTRIES (8) loads, and an insert uses a free entry while one exists. When the table is full, an insert evicts entries in round-robin order starting at the first-filled one. A check of an evicted tag answers replay.
- R8: If an insert and a store to the same word arrive in one cycle, the new entry is not violated.
- R9: If a store and a check arrive in one cycle and the store hits the checked entry, the check answers replay.
- R10: If a check and an insert of the same tag arrive in one cycle, the check answers from the old entry, and the table then holds the newly inserted address under that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Speculative load issues this cycle |
| ins_tag | input | TAG_W | Destination tag of the issuing load |
| ins_addr | input | ADDR_W | Byte address of the issuing load |
| st_valid | input | 1 | Store snoop this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | TAG_W | Tag being checked |
| resp_valid | output | 1 | Check answer present |
| resp_replay | output | 1 | 1: the load must run again; 0: keep its value |

## Verification
The assertions check on every cycle that a check's answer lags its request by exactly one cycle, and that no live entry shares its word with the store of the previous cycle. They also check that no live entry keeps a tag checked in the previous cycle, and that live tags stay unique. The bench scenarios are needed for the rest: round-robin eviction order, the overwrite of a repeated tag, byte offsets within a word, and the ordering of operations that share a cycle. All of these show up only in the replay answers of later checks.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 5,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              resp_valid,
  output logic              resp_replay
);
  localparam int WORD_W = ADDR_W - OFS_W;
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][WORD_W-1:0] ent_word;
  logic [IDX_W-1:0]               rr_ptr;

  wire [WORD_W-1:0] st_word  = st_addr[ADDR_W-1:OFS_W];
  wire [WORD_W-1:0] ins_word = ins_addr[ADDR_W-1:OFS_W];

  logic [ENTRIES-1:0] st_hit, chk_hit, vld_mid, ins_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign st_hit[i]  = st_valid && ent_vld[i] && (ent_word[i] == st_word);
    assign chk_hit[i] = chk_valid && ent_vld[i] && !st_hit[i] && (ent_tag[i] == chk_tag);
    assign vld_mid[i] = ent_vld[i] && !st_hit[i] && !chk_hit[i];
    assign ins_hit[i] = vld_mid[i] && (ent_tag[i] == ins_tag);
  end

  logic [IDX_W-1:0] ins_idx;
  logic             use_rr;

  always_comb begin
    ins_idx = rr_ptr;
    use_rr  = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_mid[i]) begin
        ins_idx = IDX_W'(i);
        use_rr  = 1'b0;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_hit[i]) begin
        ins_idx = IDX_W'(i);
        use_rr  = 1'b0;
      end
    end
  end

  wire [IDX_W-1:0] rr_next = (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld     <= '0;
      rr_ptr      <= '0;
      resp_valid  <= 1'b0;
      resp_replay <= 1'b0;
    end else begin
      ent_vld <= vld_mid;
      if (ins_valid) begin
        ent_vld[ins_idx] <= 1'b1;
        if (use_rr) rr_ptr <= rr_next;
      end
      resp_valid  <= chk_valid;
      resp_replay <= chk_valid && !(|chk_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      ent_tag[ins_idx]  <= ins_tag;
      ent_word[ins_idx] <= ins_word;
    end
  end
endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 5,
  parameter int WORD_W  = 30,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ins_valid,
  input logic                             st_valid,
  input logic [ADDR_W-1:0]                st_addr,
  input logic                             chk_valid,
  input logic [TAG_W-1:0]                 chk_tag,
  input logic                             resp_valid,
  input logic                             resp_replay,
  input logic [ENTRIES-1:0]               ent_vld,
  input logic [ENTRIES-1:0][TAG_W-1:0]    ent_tag,
  input logic [ENTRIES-1:0][WORD_W-1:0]   ent_word
);
  logic              st_q, chk_q;
  logic [WORD_W-1:0] st_word_q;
  logic [TAG_W-1:0]  chk_tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      chk_q <= 1'b0;
      st_word_q <= '0;
      chk_tag_q <= '0;
    end else begin
      st_q  <= st_valid && !ins_valid;
      chk_q <= chk_valid && !ins_valid;
      st_word_q <= st_addr[ADDR_W-1:OFS_W];
      chk_tag_q <= chk_tag;
    end
  end

  logic [ENTRIES-1:0] word_live, tag_live;
  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      word_live[i] = ent_vld[i] && (ent_word[i] == st_word_q);
      tag_live[i]  = ent_vld[i] && (ent_tag[i] == chk_tag_q);
      for (int j = i + 1; j < ENTRIES; j++)
        if (ent_vld[i] && ent_vld[j] && ent_tag[i] == ent_tag[j]) dup_tag = 1'b1;
    end
  end

  // R2
  resp_lag_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_valid |=> resp_valid);
  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !chk_valid |=> !resp_valid);
  // R2
  replay_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) resp_replay |-> resp_valid);
  // R3
  store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q |-> (word_live == '0));
  // R5
  check_retire_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_q |-> (tag_live == '0));
  // R6
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);
endmodule

bind spec_load_table spec_load_table_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .WORD_W(ADDR_W - OFS_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .st_valid(st_valid), .st_addr(st_addr),
  .chk_valid(chk_valid), .chk_tag(chk_tag), .resp_valid(resp_valid), .resp_replay(resp_replay),
  .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_word(ent_word)
);

// File: tb/spec_load_table_tb_top.sv
`timescale 1ns/1ps
module spec_load_table_tb_top;
  localparam int TAG_W = 5;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [TAG_W-1:0] ins_tag = '0, chk_tag = '0;
  logic [ADDR_W-1:0] ins_addr = '0, st_addr = '0;
  logic resp_valid, resp_replay;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spec_load_table dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .resp_valid(resp_valid), .resp_replay(resp_replay)
  );

  task automatic expect1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic op(input logic iv, input int it, input int ia,
                    input logic sv, input int sa, input logic cv, input int ct);
    ins_valid = iv; ins_tag = TAG_W'(it); ins_addr = ADDR_W'(ia);
    st_valid = sv; st_addr = ADDR_W'(sa);
    chk_valid = cv; chk_tag = TAG_W'(ct);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic ins(input int t, input int a); op(1, t, a, 0, 0, 0, 0); endtask
  task automatic st(input int a); op(0, 0, 0, 1, a, 0, 0); endtask

  task automatic check_tag(input string req, input int t, input logic exp);
    op(0, 0, 0, 0, 0, 1, t);
    expect1({req, " resp_valid"}, resp_valid, 1'b1);
    expect1({req, " replay"}, resp_replay, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    expect1("R1 resp_valid idle", resp_valid, 1'b0);
    for (int t = 0; t < 4; t++) check_tag("R1 empty table", t, 1'b1);
    // R2: no check, no response
    op(0, 0, 0, 0, 0, 0, 0);
    expect1("R2 idle resp_valid", resp_valid, 1'b0);
    expect1("R2 idle replay", resp_replay, 1'b0);
    ins(3, 'h40);
    check_tag("R2 hit keeps value", 3, 1'b0);

    // R3/R4 byte offset and word sweep
    for (int o = 0; o < 4; o++) begin
      for (int w = -1; w <= 1; w++) begin
        ins(9, 'h200 + o);
        st('h200 + 4 * w + o);
        check_tag(w == 0 ? "R3 same word" : "R4 other word", 9, w == 0);
      end
    end

    // R3/R4 full table, one conflicting store
    for (int v = 0; v < 8; v++) begin
      do_reset();
      for (int k = 0; k < 8; k++) ins(k, 'h1000 + 16 * k);
      st('h1000 + 16 * v + 3);
      for (int k = 0; k < 8; k++) check_tag(k == v ? "R3 victim" : "R4 bystander", k, k == v);
    end

    // R5
    do_reset();
    ins(2, 'h80);
    check_tag("R5 first check", 2, 1'b0);
    check_tag("R5 retired", 2, 1'b1);

    // R6
    ins(7, 'h300);
    ins(7, 'h400);
    st('h300);
    check_tag("R6 old word ignored", 7, 1'b0);
    ins(7, 'h300);
    ins(7, 'h400);
    st('h401);
    check_tag("R6 new word conflicts", 7, 1'b1);

    // R7 eviction order
    for (int n = 0; n < 3; n++) begin
      do_reset();
      for (int k = 0; k < 8 + n; k++) ins(k, 'h2000 + 8 * k);
      for (int k = 0; k < 8 + n; k++) check_tag("R7 eviction", k, k < n);
    end

    // R8
    do_reset();
    op(1, 4, 'h500, 1, 'h502, 0, 0);
    check_tag("R8 insert after store", 4, 1'b0);
    // R9
    ins(5, 'h600);
    op(0, 0, 0, 1, 'h600, 1, 5);
    expect1("R9 resp_valid", resp_valid, 1'b1);
    expect1("R9 store before check", resp_replay, 1'b1);
    // R10
    ins(6, 'h700);
    op(1, 6, 'h800, 0, 0, 1, 6);
    expect1("R10 resp_valid", resp_valid, 1'b1);
    expect1("R10 old entry answered", resp_replay, 1'b0);
    st('h700);
    check_tag("R10 new address kept", 6, 1'b0);
    ins(6, 'h700);
    op(1, 6, 'h800, 0, 0, 1, 6);
    st('h800);
    check_tag("R10 new address live", 6, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule